// File: doc/BRIEF.md
# Dependency-Ordered Power-Good Sequencer

This block turns the power-good flags of three supply domains into ordered domain releases, a system power-good and a stretched system reset. The order is fixed: the core domain first, the memory domain second and the I/O domain last. Each domain has its own delay timer. The timer runs only while that domain's entry condition holds. If the condition drops before the timer expires, the timer is cancelled and restarts from zero.

All timing counts ticks of a common time base. A prescaler divides the clock by `TICK_DIV` to make one tick per microsecond, and 16-bit counters count those ticks. The three delays and the reset width are inputs, so firmware or straps can set them anywhere from a couple of milliseconds to tens of milliseconds. Each time a domain's entry condition collapses, the block counts one failed attempt. After a programmable number of failures it parks in a safe lock with every output quiet, so a rail that never settles cannot make the reset toggle forever. Only an explicit clear pulse leaves the lock.

Top module: `pgs_sequencer`

## Requirements
- R1: Releases are ordered. `dom_en[2]` (I/O) is never high unless `dom_en[1]` (memory) is high, and `dom_en[1]` is never high unless `dom_en[0]` (core) is high.
- R2: Each domain has an entry condition:
  - core: `rail_pg[0]` and not locked;
  - memory: core released, `rail_pg[1]` and `clk_ok`;
  - I/O: memory released and `rail_pg[2]`.

  A tick occurs in clock cycles `TICK_DIV-1`, `2*TICK_DIV-1` and so on after reset. A domain releases in the cycle after the d-th tick counted while its condition held, where d is its delay input (0 is treated as 1). The release therefore comes between (d-1)*TICK_DIV+1 and d*TICK_DIV cycles after the condition rose.
- R3: If a domain's condition falls before its timer expires, the count is discarded and no release occurs. When the condition returns, the full delay is counted again.
- R4: The memory domain is never released while `rail_pg[0]` or `clk_ok` is low.
- R5: `sys_pg` is high only while the I/O domain is released. Any single low `rail_pg` bit drops it in the same cycle.
- R6: When a domain's condition drops, that release and every release downstream of it fall in the same cycle. Releases upstream of it are kept.
- R7: `sys_rst_n` is low whenever `sys_pg` is low. After `sys_pg` rises, `sys_rst_n` rises after `rst_width` ticks (0 treated as 1), that is between (w-1)*TICK_DIV+1 and w*TICK_DIV cycles later.
- R8: Each cycle in which at least one domain condition falls counts one failed attempt. The count reaching `retry_limit` (0 treated as 1) sets `safe_lock` in the next cycle.
- R9: While `safe_lock` is high, `dom_en` is 0, `sys_pg` is 0 and `sys_rst_n` is 0.
- R10: `safe_lock` stays set, whatever the rails do, until a cycle with `safe_clr` high. That cycle clears both the lock and the failure count.
- R11: While `rst_n` is low, every release, `sys_pg`, `sys_rst_n` and `safe_lock` are 0.
- R12: `rail_pg[2]` has no effect on when the core and memory domains are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_pg | input | 3 | Rail good flags: bit 0 core, bit 1 memory, bit 2 I/O |
| clk_ok | input | 1 | Clock-stable flag gating the memory release |
| dly_core | input | CW | Core release delay in ticks |
| dly_mem | input | CW | Memory release delay in ticks |
| dly_io | input | CW | I/O release delay in ticks |
| rst_width | input | CW | Reset stretch after `sys_pg` rises, in ticks |
| retry_limit | input | FW | Failed attempts that trigger the safe lock |
| safe_clr | input | 1 | Clears the lock and the failure count |
| dom_en | output | 3 | Domain releases: bit 0 core, bit 1 memory, bit 2 I/O |
| sys_pg | output | 1 | System power-good |
| sys_rst_n | output | 1 | Stretched active-low system reset |
| safe_lock | output | 1 | Safe-state indication |

## Verification
The embedded assertions check the cycle-level invariants on every cycle:
- the release ordering;
- the memory gate on core power-good and `clk_ok`;
- the immediate revocation of `sys_pg` by any bad rail;
- releases and reset deassertion happening only on a tick;
- the silence and stickiness of the lock.

The delay lengths, the cancellation and full restart after a short-lived condition, the exact failure count that triggers the lock, the reset stretch length and the independence of upstream releases from the I/O rail are timing and history matters. Only the bench's scenarios and its cycle-by-cycle reference model show those.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  localparam int TMR_W  = 16;
  localparam int FAIL_W = 4;
  localparam int NDOM   = 3;

  // True when one more increment meets the programmed limit (0 acts as 1).
  function automatic logic reached(input int unsigned count, input int unsigned limit);
    return (count + 1) >= limit;
  endfunction
endpackage

// File: rtl/pgs_tick.sv
module pgs_tick #(
  parameter int DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/pgs_stage.sv
module pgs_stage #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          gate,
  input  logic [CW-1:0] limit,
  output logic          en
);
  logic [CW-1:0] cnt_q;
  logic          rel_q;
  logic          expire;

  assign expire = gate && !rel_q && tick && pgs_pkg::reached(32'(cnt_q), 32'(limit));
  assign en     = rel_q && gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!gate) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (expire) begin
      rel_q <= 1'b1;
    end else if (!rel_q && tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> ($past(tick) && $past(gate)));
  assert_cancel_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> !en);
endmodule

// File: rtl/pgs_stretch.sv
module pgs_stretch #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pg,
  input  logic [CW-1:0] width,
  output logic          rst_out_n
);
  logic [CW-1:0] cnt_q;
  logic          act_q;

  assign rst_out_n = pg && !act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (!pg) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q && tick) begin
      if (pgs_pkg::reached(32'(cnt_q), 32'(width))) act_q <= 1'b0;
      else                                         cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_rst_rise_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> ($past(tick) && $past(pg)));
endmodule

// File: rtl/pgs_retry.sv
module pgs_retry #(
  parameter int NG = 3,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NG-1:0] gates,
  input  logic [FW-1:0] limit,
  input  logic          clr,
  output logic          lock
);
  logic [NG-1:0] gate_q;
  logic [FW-1:0] fails_q;
  logic          lock_q;
  logic          fail_evt;

  assign fail_evt = (|(gate_q & ~gates)) && !lock_q;
  assign lock     = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= '0;
      fails_q <= '0;
      lock_q  <= 1'b0;
    end else begin
      gate_q <= gates;
      if (clr) begin
        fails_q <= '0;
        lock_q  <= 1'b0;
      end else if (fail_evt) begin
        if (pgs_pkg::reached(32'(fails_q), 32'(limit))) lock_q  <= 1'b1;
        else                                           fails_q <= fails_q + 1'b1;
      end
    end
  end

  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !clr) |=> lock);
  assert_clear_unlocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !lock);
endmodule

// File: rtl/pgs_sequencer.sv
module pgs_sequencer #(
  parameter int TICK_DIV = 200,
  parameter int CW       = pgs_pkg::TMR_W,
  parameter int FW       = pgs_pkg::FAIL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    rail_pg,
  input  logic          clk_ok,
  input  logic [CW-1:0] dly_core,
  input  logic [CW-1:0] dly_mem,
  input  logic [CW-1:0] dly_io,
  input  logic [CW-1:0] rst_width,
  input  logic [FW-1:0] retry_limit,
  input  logic          safe_clr,
  output logic [2:0]    dom_en,
  output logic          sys_pg,
  output logic          sys_rst_n,
  output logic          safe_lock
);
  localparam int ND = pgs_pkg::NDOM;

  logic tick;
  logic lock;
  logic gate_core, gate_mem, gate_io;
  logic en_core, en_mem, en_io;
  logic [ND-1:0] gates;

  // Conditions flow strictly downstream; nothing feeds back upstream.
  assign gate_core = rail_pg[0] && !lock;
  assign gate_mem  = en_core && rail_pg[1] && clk_ok;
  assign gate_io   = en_mem && rail_pg[2];
  assign gates     = {gate_io, gate_mem, gate_core};

  pgs_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  pgs_stage #(.CW(CW)) u_core (.clk(clk), .rst_n(rst_n), .tick(tick),
    .gate(gate_core), .limit(dly_core), .en(en_core));
  pgs_stage #(.CW(CW)) u_mem  (.clk(clk), .rst_n(rst_n), .tick(tick),
    .gate(gate_mem), .limit(dly_mem), .en(en_mem));
  pgs_stage #(.CW(CW)) u_io   (.clk(clk), .rst_n(rst_n), .tick(tick),
    .gate(gate_io), .limit(dly_io), .en(en_io));

  pgs_stretch #(.CW(CW)) u_stretch (.clk(clk), .rst_n(rst_n), .tick(tick),
    .pg(en_io), .width(rst_width), .rst_out_n(sys_rst_n));

  pgs_retry #(.NG(ND), .FW(FW)) u_retry (.clk(clk), .rst_n(rst_n), .gates(gates),
    .limit(retry_limit), .clr(safe_clr), .lock(lock));

  assign dom_en    = {en_io, en_mem, en_core};
  assign sys_pg    = en_io;
  assign safe_lock = lock;

  assert_order_io_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dom_en[2] |-> dom_en[1]);
  assert_order_mem_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dom_en[1] |-> dom_en[0]);
  assert_mem_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dom_en[1] |-> (rail_pg[0] && clk_ok));
  assert_bad_rail_revokes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_pg != 3'b111) |-> !sys_pg);
  assert_lock_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    safe_lock |-> (dom_en == 3'b000 && !sys_pg && !sys_rst_n));
endmodule

// File: tb/pgs_sequencer_tb.sv
`timescale 1ns/1ps
module pgs_sequencer_tb;
  localparam int T  = 4;
  localparam int CW = 16;
  localparam int FW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] pg = 3'b000;
  logic ck_ok = 1'b0;
  logic [CW-1:0] d_core = 16'd3, d_mem = 16'd4, d_io = 16'd2, r_w = 16'd5;
  logic [FW-1:0] lim = 4'd3;
  logic clr = 1'b0;
  logic [2:0] en;
  logic spg, srn, lck;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pgs_sequencer #(.TICK_DIV(T), .CW(CW), .FW(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rail_pg(pg), .clk_ok(ck_ok),
    .dly_core(d_core), .dly_mem(d_mem), .dly_io(d_io), .rst_width(r_w),
    .retry_limit(lim), .safe_clr(clr),
    .dom_en(en), .sys_pg(spg), .sys_rst_n(srn), .safe_lock(lck));

  // Behavioural reference model
  int m_pre, m_rc, m_fail;
  int m_cnt[3];
  bit m_rel[3], m_gp[3], mg[3], me[3];
  bit m_ract, m_lock, m_tick;

  function automatic int dly_of(int k);
    return (k == 0) ? int'(d_core) : (k == 1) ? int'(d_mem) : int'(d_io);
  endfunction

  function automatic void model_eval();
    m_tick = (m_pre == T - 1);
    mg[0] = pg[0] && !m_lock;
    me[0] = mg[0] && m_rel[0];
    mg[1] = me[0] && pg[1] && ck_ok;
    me[1] = mg[1] && m_rel[1];
    mg[2] = me[1] && pg[2];
    me[2] = mg[2] && m_rel[2];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_pre = 0; m_rc = 0; m_fail = 0; m_ract = 1; m_lock = 0;
      foreach (m_cnt[k]) begin m_cnt[k] = 0; m_rel[k] = 0; m_gp[k] = 0; end
    end else begin
      bit fell;
      model_eval();
      fell = 0;
      for (int k = 0; k < 3; k++) begin
        if (m_gp[k] && !mg[k]) fell = 1;
        if (!mg[k]) begin m_cnt[k] = 0; m_rel[k] = 0; end
        else if (!m_rel[k] && m_tick) begin
          if (m_cnt[k] + 1 >= dly_of(k)) m_rel[k] = 1; else m_cnt[k]++;
        end
      end
      if (!me[2]) begin m_rc = 0; m_ract = 1; end
      else if (m_ract && m_tick) begin
        if (m_rc + 1 >= int'(r_w)) m_ract = 0; else m_rc++;
      end
      if (clr) begin m_fail = 0; m_lock = 0; end
      else if (!m_lock && fell) begin
        if (m_fail + 1 >= int'(lim)) m_lock = 1; else m_fail++;
      end
      for (int k = 0; k < 3; k++) m_gp[k] = mg[k];
      m_pre = (m_pre == T - 1) ? 0 : m_pre + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      model_eval();
      check(en == {me[2], me[1], me[0]}, "R2", int'(en), int'({me[2], me[1], me[0]}));
      check(spg == me[2], "R5", int'(spg), int'(me[2]));
      check(srn == (me[2] && !m_ract), "R7", int'(srn), int'(me[2] && !m_ract));
      check(lck == m_lock, "R9", int'(lck), int'(m_lock));
    end
  end

  // Rise-time capture
  int rise_c, rise_m, rise_i, rise_r;
  logic [2:0] en_p;
  logic srn_p;
  always @(negedge clk) begin
    if (en[0] && !en_p[0]) rise_c = cyc;
    if (en[1] && !en_p[1]) rise_m = cyc;
    if (en[2] && !en_p[2]) rise_i = cyc;
    if (srn && !srn_p) rise_r = cyc;
    en_p = en;
    srn_p = srn;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pg = 3'b000; ck_ok = 1'b0; clr = 1'b0;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic in_window(input int diff, input int d, input string req);
    check(diff >= (d - 1) * T + 1 && diff <= d * T, req, diff, d * T);
  endtask

  initial begin
    step(1);
    // R11: outputs quiet under reset
    check(en == 3'b000 && !spg && !srn && !lck, "R11", int'({en, spg, srn, lck}), 0);
    do_reset();

    // Normal bring-up: R1, R2, R7
    pg = 3'b111; ck_ok = 1'b1;
    step(120);
    check(en == 3'b111 && spg && srn, "R1", int'({en, spg, srn}), 31);
    check(rise_c < rise_m && rise_m < rise_i, "R1", rise_m, rise_c + 1);
    in_window(rise_m - rise_c, 4, "R2");
    in_window(rise_i - rise_m, 2, "R2");
    in_window(rise_r - rise_i, 5, "R7");

    // R5 / R6: one bad I/O rail revokes sys_pg, upstream releases remain
    pg = 3'b011;
    step(0);
    @(negedge clk);
    check(!spg && !srn, "R5", int'({spg, srn}), 0);
    check(en == 3'b011, "R6", int'(en), 3);
    step(1);
    pg = 3'b111;
    step(60);
    check(spg && srn, "R7", int'({spg, srn}), 3);

    // R12: I/O rail absent, core and memory still release on time
    do_reset();
    pg = 3'b011; ck_ok = 1'b1;
    step(80);
    check(en == 3'b011 && !spg, "R12", int'(en), 3);
    in_window(rise_m - rise_c, 4, "R12");

    // R4: clk_ok low blocks memory
    do_reset();
    pg = 3'b111; ck_ok = 1'b0;
    step(60);
    check(en == 3'b001, "R4", int'(en), 1);

    // R3: short-lived clk_ok, pending memory timer cancelled
    ck_ok = 1'b1; step(6);
    ck_ok = 1'b0; step(3);
    check(en[1] == 1'b0, "R3", int'(en[1]), 0);
    ck_ok = 1'b1; step(10);
    check(en[1] == 1'b0, "R3", int'(en[1]), 0);
    step(60);
    check(en == 3'b111 && !lck, "R3", int'({en, lck}), 14);

    // R8 / R9 / R10: three failures lock, only safe_clr recovers
    do_reset();
    pg = 3'b111; ck_ok = 1'b1;
    step(120);
    for (int k = 0; k < 3; k++) begin
      pg = 3'b110; step(1);
      pg = 3'b111; step(1);
      @(negedge clk);
      check(lck == (k == 2), "R8", int'(lck), int'(k == 2));
      step(20);
    end
    check(en == 3'b000 && !spg && !srn, "R9", int'({en, spg, srn}), 0);
    step(150);
    check(lck && en == 3'b000, "R10", int'({lck, en}), 8);
    clr = 1'b1; step(1); clr = 1'b0;
    step(150);
    check(!lck && en == 3'b111 && spg && srn, "R10", int'({lck, en, spg, srn}), 15);

    // R8 boundary: limit 0 locks on the first failure
    lim = 4'd0;
    pg = 3'b011; step(1);
    pg = 3'b111; step(2);
    check(lck == 1'b1, "R8", int'(lck), 1);
    lim = 4'd3;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule